// File: doc/BRIEF.md
# Packed SIMD Lane Rotate Unit

This execution unit rotates every element of a 128-bit packed vector to the right. A two-bit size select picks how the vector is divided into elements. The choices are sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. Bits that leave the low end of a lane re-enter at the high end of the same lane. No bit ever moves into a neighbouring lane.

The rotate amount comes from one of two places. In per-lane mode, each lane takes its own amount from the matching lane of a second vector operand. In broadcast mode, a single immediate applies to every lane. In both modes the amount is cut down to the bits that can address a position inside the lane. The unit is a two-register pipeline that accepts a new operation on every clock, and a valid flag travels alongside the data.

Top module: `simd_lane_rotator`

## Requirements
- R1: `in_size` encodes the element width as 00=8, 01=16, 10=32 and 11=64 bits. Lane 0 sits in the least significant bits of the vector, and higher lane numbers sit in successively more significant bits.
- R2: Each lane of `out_data` is the matching lane of `in_a` rotated right. A bit shifted out of lane bit 0 reappears at the lane's top bit, and no bit crosses a lane boundary.
- R3: When `in_mode`=0, the rotate amount of lane i is the low log2(width) bits of lane i of `in_b`. That is 3, 4, 5 or 6 bits for 8-, 16-, 32- and 64-bit lanes, and higher bits of that lane have no effect.
- R4: When `in_mode`=1, every lane is rotated by the low log2(width) bits of `in_imm`, and the value of `in_b` has no effect on the result.
- R5: A rotate amount of zero returns the lane unchanged.
- R6: `out_valid` is high exactly two rising edges after an edge that sampled `in_valid` high, and `out_data` then holds that operation's result.
- R7: Operations issued on consecutive cycles each produce a result on consecutive cycles, with no bubble.
- R8: Asserting `rst_n` low clears both pipeline valid flags, so `out_valid` is low during and directly after reset, and operations in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to `clk` |
| in_valid | input | 1 | Operation present this cycle |
| in_a | input | 128 | Vector whose lanes are rotated |
| in_b | input | 128 | Per-lane rotate amounts (per-lane mode only) |
| in_imm | input | 6 | Broadcast rotate amount (broadcast mode only) |
| in_size | input | 2 | Element width select |
| in_mode | input | 1 | 0 = per-lane amount from `in_b`, 1 = broadcast `in_imm` |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 128 | Rotated vector |

## Verification
The hardest case to reach from the ports is a lane whose amount field has bits set above the masked range, in every lane at once and for every size. This matters because an unmasked amount that is still below the lane width gives a plausible but wrong rotation. The stimulus feeds fully random 128-bit `in_b` vectors and sweeps all 64 immediate values under each size. Amounts at and beyond the lane width are therefore certain to occur. These operations are issued back to back, and a mid-flight reset drops some of them.

// File: rtl/simd_rot_pkg.sv
package simd_rot_pkg;

  localparam int VEC_W     = 128;
  localparam int NUM_SIZES = 4;
  localparam int MIN_LANE  = 8;

  typedef enum logic [1:0] {
    SZ_8  = 2'b00,
    SZ_16 = 2'b01,
    SZ_32 = 2'b10,
    SZ_64 = 2'b11
  } elem_size_e;

  // Lane width in bits for size code k.
  function automatic int lane_w(input int k);
    return MIN_LANE << k;
  endfunction

  // Bits of rotate amount that are meaningful for size code k.
  function automatic int amt_w(input int k);
    return $clog2(MIN_LANE) + k;
  endfunction

endpackage

// File: rtl/simd_rot_count.sv
// Resolves the rotate amount of every lane, for the selected size, into a
// vector laid out like the data: each lane carries its masked amount in its
// low bits and zeros above.
module simd_rot_count
  import simd_rot_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int IMM_W = 6
) (
  input  logic [VW-1:0]    amt_vec,
  input  logic [IMM_W-1:0] amt_imm,
  input  logic             use_imm,
  input  elem_size_e       size,
  output logic [VW-1:0]    cnt
);

  logic [VW-1:0] per_size [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W  = lane_w(k);
    localparam int SH = amt_w(k);
    localparam int N  = VW / W;
    logic [VW-1:0] vec;
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [SH-1:0] amt;
      assign amt = use_imm ? amt_imm[SH-1:0] : amt_vec[l*W +: SH];
      assign vec[l*W +: W] = {{(W-SH){1'b0}}, amt};
    end
    assign per_size[k] = vec;
  end

  always_comb begin
    cnt = per_size[int'(size)];
  end

endmodule

// File: rtl/simd_rot_lanes.sv
// Rotate network: one copy per element size, result chosen by size.
module simd_rot_lanes
  import simd_rot_pkg::*;
#(
  parameter int VW = VEC_W
) (
  input  logic [VW-1:0] data,
  input  logic [VW-1:0] cnt,
  input  elem_size_e    size,
  output logic [VW-1:0] result
);

  logic [VW-1:0] per_size [NUM_SIZES];

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_size
    localparam int W  = lane_w(k);
    localparam int SH = amt_w(k);
    localparam int N  = VW / W;
    logic [VW-1:0] vec;
    for (genvar l = 0; l < N; l++) begin : g_lane
      logic [W-1:0]   x;
      logic [SH-1:0]  c;
      logic [2*W-1:0] dbl;
      assign x   = data[l*W +: W];
      assign c   = cnt[l*W +: SH];
      assign dbl = {x, x} >> c;
      assign vec[l*W +: W] = dbl[W-1:0];
    end
    assign per_size[k] = vec;
  end

  always_comb begin
    result = per_size[int'(size)];
  end

endmodule

// File: rtl/simd_rot_stage.sv
// One pipeline register: reset valid flag, enable-gated data without reset.
module simd_rot_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] dat_i,
  output logic         vld_o,
  output logic [W-1:0] dat_o
);

  logic         vld_d, vld_q;
  logic         dat_en;
  logic [W-1:0] dat_q;

  always_comb begin
    vld_d  = vld_i;
    dat_en = vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (dat_en) dat_q <= dat_i;
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;

endmodule

// File: rtl/simd_lane_rotator.sv
module simd_lane_rotator
  import simd_rot_pkg::*;
#(
  parameter int VW    = VEC_W,
  parameter int IMM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VW-1:0]    in_a,
  input  logic [VW-1:0]    in_b,
  input  logic [IMM_W-1:0] in_imm,
  input  logic [1:0]       in_size,
  input  logic             in_mode,
  output logic             out_valid,
  output logic [VW-1:0]    out_data
);

  localparam int S1_W = 2 + 2 * VW;

  elem_size_e    size_in;
  logic [VW-1:0] cnt_in;
  logic [S1_W-1:0] s1_d, s1_q;
  logic          s1_vld;
  logic [VW-1:0] a_q, cnt_q, rot;
  elem_size_e    size_q;

  assign size_in = elem_size_e'(in_size);

  // Stage 1 input side: amount selection and masking.
  simd_rot_count #(.VW(VW), .IMM_W(IMM_W)) u_count (
    .amt_vec (in_b),
    .amt_imm (in_imm),
    .use_imm (in_mode),
    .size    (size_in),
    .cnt     (cnt_in)
  );

  assign s1_d = {in_size, cnt_in, in_a};

  simd_rot_stage #(.W(S1_W)) u_stage1 (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .dat_i (s1_d),
    .vld_o (s1_vld),
    .dat_o (s1_q)
  );

  assign a_q    = s1_q[VW-1:0];
  assign cnt_q  = s1_q[2*VW-1:VW];
  assign size_q = elem_size_e'(s1_q[S1_W-1 -: 2]);

  // Stage 2 input side: rotate network.
  simd_rot_lanes #(.VW(VW)) u_lanes (
    .data   (a_q),
    .cnt    (cnt_q),
    .size   (size_q),
    .result (rot)
  );

  simd_rot_stage #(.W(VW)) u_stage2 (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (s1_vld),
    .dat_i (rot),
    .vld_o (out_valid),
    .dat_o (out_data)
  );

endmodule

// File: rtl/simd_rot_checker.sv
module simd_rot_checker #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          s1_vld,
  input logic [VW-1:0] a_q,
  input logic [VW-1:0] cnt_q,
  input logic          out_valid,
  input logic [VW-1:0] out_data
);

  // R6: valid moves one stage per edge
  a_r6_stage1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_vld);
  a_r6_stage1_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_vld);
  a_r6_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid);
  a_r6_out_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_valid);

  // R2: a rotation inside lanes keeps the number of set bits
  a_r2_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> $countones(out_data) == $countones($past(a_q)));

  // R5: all-zero amounts leave data unchanged
  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && cnt_q == '0) |=> out_data == $past(a_q));

  // R7: back-to-back issue keeps both stages full
  a_r7_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && in_valid) |=> (s1_vld && out_valid));

endmodule

bind simd_lane_rotator simd_rot_checker #(.VW(VW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .s1_vld    (s1_vld),
  .a_q       (a_q),
  .cnt_q     (cnt_q),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/simd_lane_rotator_tb_top.sv
`timescale 1ns/1ps
module simd_lane_rotator_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_a, in_b;
  logic [5:0]   in_imm;
  logic [1:0]   in_size;
  logic         in_mode;
  logic         out_valid;
  logic [127:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  // expected pipeline in the bench
  bit           pv1 = 0, pv2 = 0;
  logic [127:0] pe1, pe2;
  string        pt1, pt2;

  always #5 clk = ~clk;

  simd_lane_rotator dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .in_imm(in_imm), .in_size(in_size), .in_mode(in_mode),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] rnd64();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  function automatic logic [127:0] rnd128();
    logic [63:0] hi, lo;
    hi = rnd64();
    lo = rnd64();
    return {hi, lo};
  endfunction

  // Reference: arithmetic rotate per lane, amount taken modulo lane width.
  function automatic logic [127:0] ref_rot(logic [127:0] a, logic [127:0] b,
                                           logic [5:0] imm, int sz, bit md);
    int w = 8 << sz;
    logic [127:0] m = (128'd1 << w) - 128'd1;
    logic [127:0] r = '0;
    for (int l = 0; l < 128 / w; l++) begin
      logic [127:0] x, y;
      int c;
      x = (a >> (l * w)) & m;
      c = md ? int'(imm) : int'((b >> (l * w)) & 128'hFF);
      c = c % w;
      y = (c == 0) ? x : (((x >> c) | (x << (w - c))) & m);
      r = r | (y << (l * w));
    end
    return r;
  endfunction

  task automatic fail(string req, logic [127:0] act, logic [127:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic issue(bit v, logic [127:0] a, logic [127:0] b, logic [5:0] imm,
                       int sz, bit md, string tag);
    @(negedge clk);
    checks++;
    if (out_valid !== pv2) fail("R6 valid", 128'(out_valid), 128'(pv2));
    if (pv2) begin
      checks++;
      if (out_data !== pe2) fail(pt2, out_data, pe2);
    end
    pv2 = pv1; pe2 = pe1; pt2 = pt1;
    pv1 = v;   pe1 = ref_rot(a, b, imm, sz, md); pt1 = tag;
    in_valid = v; in_a = a; in_b = b; in_imm = imm;
    in_size = 2'(sz); in_mode = md;
  endtask

  task automatic flush();
    repeat (3) issue(0, '0, '0, '0, 0, 0, "idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; in_a = '0; in_b = '0; in_imm = '0;
    in_size = '0; in_mode = 0;
    repeat (3) @(negedge clk);
    checks++;  // R8: reset state
    if (out_valid !== 1'b0) fail("R8 reset", 128'(out_valid), 128'd0);
    rst_n = 1;

    // R1: lane 0 at the bottom; bit 0 of each lane rotated by 1 lands on top bit
    for (int sz = 0; sz < 4; sz++) begin
      int w = 8 << sz;
      logic [127:0] ones = '0;
      for (int l = 0; l < 128 / w; l++) ones = ones | (128'd1 << (l * w));
      issue(1, 128'd1, '0, 6'd1, sz, 1, "R1 lane0");
      issue(1, ones, ones, 6'd0, sz, 0, "R1 every lane");
    end
    flush();

    // R2/R3: random data, random full-width amount vectors (high bits set)
    for (int sz = 0; sz < 4; sz++)
      for (int i = 0; i < 64; i++)
        issue(1, rnd128(), rnd128(), rnd64()[5:0], sz, 0, "R3 per-lane masked");
    flush();

    // R4: every immediate value, random b that must be ignored
    for (int sz = 0; sz < 4; sz++)
      for (int i = 0; i < 64; i++) begin
        logic [127:0] a = rnd128();
        issue(1, a, rnd128(), 6'(i), sz, 1, "R4 immediate");
        issue(1, a, ~in_b, 6'(i), sz, 1, "R4 b ignored");
      end
    flush();

    // R5 zero amount, R2 width-1 amount in every lane
    for (int sz = 0; sz < 4; sz++) begin
      int w = 8 << sz;
      logic [127:0] wm1 = '0;
      for (int l = 0; l < 128 / w; l++) wm1 = wm1 | (128'(w - 1) << (l * w));
      issue(1, rnd128(), '0, 6'd0, sz, 0, "R5 zero reg");
      issue(1, rnd128(), rnd128(), 6'd0, sz, 1, "R5 zero imm");
      issue(1, rnd128(), wm1, 6'd0, sz, 0, "R2 width-1");
    end
    flush();

    // R7: gaps then bursts; result follows every issue without bubbles
    for (int i = 0; i < 40; i++)
      issue((i % 5) != 2, rnd128(), rnd128(), rnd64()[5:0], i % 4, i[0], "R7 burst");
    flush();

    // R8: reset with operations in flight drops them
    issue(1, rnd128(), rnd128(), 6'd3, 1, 0, "R8 pre");
    issue(1, rnd128(), rnd128(), 6'd5, 2, 1, "R8 pre");
    @(negedge clk);
    rst_n = 0; in_valid = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) fail("R8 in-flight", 128'(out_valid), 128'd0);
    @(negedge clk);
    rst_n = 1;
    pv1 = 0; pv2 = 0;
    issue(0, '0, '0, '0, 0, 0, "idle");
    checks++;
    if (out_valid !== 1'b0) fail("R8 after", 128'(out_valid), 128'd0);
    issue(1, rnd128(), rnd128(), 6'd7, 3, 0, "R8 resume");
    flush();

    finish_run();
  end

endmodule